// File: doc/BRIEF.md
# Balanced Ternary Trit-wise Logic Unit

This unit applies one three-valued logic function, trit by trit, to two balanced-ternary operand words and returns a result word of the same width. Every trit is one of -1, 0 or +1 and travels on a pair of binary wires. A three-bit selector picks the function. The choices are minimum, maximum, negation of operand A, a carry-free cyclic sum, a reflection of A about a pivot taken from B, and a pass-through of A.

Each trit position is computed on its own, with no signal crossing between neighbouring positions. An illegal wire code on any input trit zeroes that position and raises an error flag for that cycle only. By default a result register captures the result on a valid input and presents it one clock later, together with a matching valid output. A parameter can remove the register so that the path becomes purely combinational.

Top module: `ternary_logic_unit`

## Requirements
- R1: Trit wire codes are 2'b00 = 0, 2'b01 = +1 and 2'b10 = -1, and 2'b11 is illegal. No result trit ever carries 2'b11.
- R2: With op_sel = 0, each result trit is the smaller of the A and B trits under the order -1 < 0 < +1.
- R3: With op_sel = 1, each result trit is the larger of the A and B trits.
- R4: With op_sel = 2, each result trit is the negation of the A trit, and the value of B has no effect.
- R5: With op_sel = 3, each result trit is A + B wrapped into -1..+1 modulo 3: B = -1 steps A down, B = 0 leaves A unchanged, and B = +1 steps A up, with no carry out.
- R6: With op_sel = 4, each result trit is A reflected about the pivot B, which equals -(A + B) wrapped modulo 3. A trit equal to the pivot stays unchanged, the other two values swap, and a pivot of 0 negates A.
- R7: With op_sel = 5, 6 or 7, the result equals operand A.
- R8: If the A or B trit at a position holds 2'b11, that result trit is 0 and err is 1 for that result. This applies under every op_sel. Other positions still compute normally.
- R9: Trit positions are independent. A mix of different trit pairs across the word yields each position's own function value.
- R10: With the register enabled, the result and err appear on the first rising edge after in_valid is sampled high, and out_valid is high for exactly that cycle. While in_valid is low, the result and err hold their last values.
- R11: Synchronous active-high reset sets the result to all-zero trits and clears err and out_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and selector are valid this cycle |
| op_sel | input | 3 | Function select (0 min, 1 max, 2 negate, 3 cyclic sum, 4 reflect, 5-7 pass A) |
| opnd_a | input | 2*TRITS | Operand A, two wires per trit, trit i at bits [2i+1:2i] |
| opnd_b | input | 2*TRITS | Operand B, same layout |
| res | output | 2*TRITS | Result word, same layout |
| err | output | 1 | An illegal code was seen in the operands of this result |
| out_valid | output | 1 | res and err belong to a valid input |

## Verification
With the default registered output, a result is due at the first rising edge after the edge that samples in_valid high. The bench drives each vector on a falling edge, lets exactly one rising edge pass, and then reads res, err and out_valid on the next falling edge, where they are stable. Hold behaviour is checked the same way: the inputs change while in_valid is low, and after the next rising edge the outputs must keep the earlier values. Reset is checked one edge after rst is raised, with in_valid held high during that edge.

// File: rtl/tlu_pkg.sv
package tlu_pkg;

    typedef enum logic [1:0] {
        T_ZERO = 2'b00,
        T_POS  = 2'b01,
        T_NEG  = 2'b10,
        T_BAD  = 2'b11
    } trit_t;

    typedef enum logic [2:0] {
        OP_MIN   = 3'd0,
        OP_MAX   = 3'd1,
        OP_NEG   = 3'd2,
        OP_ROT   = 3'd3,
        OP_REFL  = 3'd4,
        OP_PASS5 = 3'd5,
        OP_PASS6 = 3'd6,
        OP_PASS7 = 3'd7
    } op_e;

    typedef struct packed {
        trit_t value;
        logic  bad;
    } cell_out_t;

    function automatic logic signed [3:0] trit_val(input trit_t t);
        case (t)
            T_POS:   trit_val = 4'sd1;
            T_NEG:   trit_val = -4'sd1;
            default: trit_val = 4'sd0;
        endcase
    endfunction

    function automatic trit_t val_trit(input logic signed [3:0] v);
        if (v > 4'sd0)      val_trit = T_POS;
        else if (v < 4'sd0) val_trit = T_NEG;
        else                val_trit = T_ZERO;
    endfunction

    // fold a sum in -3..+3 back into -1..+1 modulo 3
    function automatic logic signed [3:0] wrap3(input logic signed [3:0] s);
        if (s > 4'sd1)       wrap3 = s - 4'sd3;
        else if (s < -4'sd1) wrap3 = s + 4'sd3;
        else                 wrap3 = s;
    endfunction

endpackage

// File: rtl/tlu_trit_cell.sv
module tlu_trit_cell
    import tlu_pkg::*;
(
    input  op_e       op,
    input  logic [1:0] a,
    input  logic [1:0] b,
    output cell_out_t  y
);
    trit_t ta, tb;
    logic signed [3:0] va, vb, r;
    logic bad;

    always_comb begin
        ta  = trit_t'(a);
        tb  = trit_t'(b);
        va  = trit_val(ta);
        vb  = trit_val(tb);
        bad = (ta == T_BAD) || (tb == T_BAD);
        case (op)
            OP_MIN:  r = (va < vb) ? va : vb;
            OP_MAX:  r = (va > vb) ? va : vb;
            OP_NEG:  r = -va;
            OP_ROT:  r = wrap3(va + vb);
            OP_REFL: r = wrap3(-(va + vb));
            default: r = va;
        endcase
        y.bad   = bad;
        y.value = bad ? T_ZERO : val_trit(r);
    end
endmodule

// File: rtl/tlu_out_stage.sv
module tlu_out_stage #(
    parameter int WORD_BITS = 12,
    parameter bit REG_OUT   = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [WORD_BITS-1:0] res_c,
    input  logic                 err_c,
    output logic [WORD_BITS-1:0] res,
    output logic                 err,
    output logic                 out_valid
);
    generate
        if (REG_OUT) begin : g_reg
            logic [WORD_BITS-1:0] res_q;
            logic                 err_q;
            logic                 vld_q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    res_q <= '0;
                    err_q <= 1'b0;
                    vld_q <= 1'b0;
                end else begin
                    vld_q <= in_valid;
                    if (in_valid) begin
                        res_q <= res_c;
                        err_q <= err_c;
                    end
                end
            end

            assign res       = res_q;
            assign err       = err_q;
            assign out_valid = vld_q;

            a_r10_valid_rise: assert property (@(posedge clk) disable iff (rst)
                in_valid |=> out_valid);
            a_r10_valid_fall: assert property (@(posedge clk) disable iff (rst)
                !in_valid |=> !out_valid);
            a_r10_hold: assert property (@(posedge clk) disable iff (rst)
                !in_valid |=> ($stable(res) && $stable(err)));
            a_r11_reset: assert property (@(posedge clk)
                rst |=> (res == '0 && !err && !out_valid));
        end else begin : g_comb
            assign res       = res_c;
            assign err       = err_c;
            assign out_valid = in_valid;
        end
    endgenerate
endmodule

// File: rtl/ternary_logic_unit.sv
module ternary_logic_unit
    import tlu_pkg::*;
#(
    parameter int TRITS   = 6,
    parameter bit REG_OUT = 1'b1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [2:0]         op_sel,
    input  logic [2*TRITS-1:0] opnd_a,
    input  logic [2*TRITS-1:0] opnd_b,
    output logic [2*TRITS-1:0] res,
    output logic               err,
    output logic               out_valid
);
    localparam int WORD_BITS = 2 * TRITS;

    op_e                  op;
    cell_out_t            cells [TRITS];
    logic [WORD_BITS-1:0] res_c;
    logic [TRITS-1:0]     bad_vec;
    logic                 err_c;

    assign op    = op_e'(op_sel);
    assign err_c = |bad_vec;

    generate
        for (genvar i = 0; i < TRITS; i++) begin : g_trit
            tlu_trit_cell u_cell (
                .op (op),
                .a  (opnd_a[2*i +: 2]),
                .b  (opnd_b[2*i +: 2]),
                .y  (cells[i])
            );
            assign res_c[2*i +: 2] = cells[i].value;
            assign bad_vec[i]      = cells[i].bad;

            a_r1_legal_trit: assert property (@(posedge clk) disable iff (rst)
                res_c[2*i +: 2] != 2'b11);
            a_r8_bad_zero: assert property (@(posedge clk) disable iff (rst)
                (opnd_a[2*i +: 2] == 2'b11 || opnd_b[2*i +: 2] == 2'b11)
                |-> (res_c[2*i +: 2] == 2'b00 && err_c));
            a_r7_pass_a: assert property (@(posedge clk) disable iff (rst)
                (op_sel >= 3'd5 && opnd_a[2*i +: 2] != 2'b11 && opnd_b[2*i +: 2] != 2'b11)
                |-> res_c[2*i +: 2] == opnd_a[2*i +: 2]);
        end
    endgenerate

    tlu_out_stage #(
        .WORD_BITS (WORD_BITS),
        .REG_OUT   (REG_OUT)
    ) u_out (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .res_c     (res_c),
        .err_c     (err_c),
        .res       (res),
        .err       (err),
        .out_valid (out_valid)
    );
endmodule

// File: tb/ternary_logic_unit_bench.sv
module ternary_logic_unit_bench;
    localparam int TRITS = 6;
    localparam int WB    = 2 * TRITS;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [2:0]    op_sel = 3'd0;
    logic [WB-1:0] opnd_a = '0;
    logic [WB-1:0] opnd_b = '0;
    logic [WB-1:0] res;
    logic          err;
    logic          out_valid;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    ternary_logic_unit #(.TRITS(TRITS), .REG_OUT(1'b1)) u_ternary_logic_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel),
        .opnd_a(opnd_a), .opnd_b(opnd_b),
        .res(res), .err(err), .out_valid(out_valid)
    );

    function automatic logic [1:0] enc(input int v);
        if (v > 0)      return 2'b01;
        else if (v < 0) return 2'b10;
        else            return 2'b00;
    endfunction

    function automatic int ref_fn(input int op, input int x, input int y);
        case (op)
            0: return (x < y) ? x : y;
            1: return (x > y) ? x : y;
            2: return -x;
            3: return ((x + y + 4) % 3) - 1;
            4: return ((4 - x - y) % 3) - 1;
            default: return x;
        endcase
    endfunction

    function automatic string tag_of(input int op);
        case (op)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            3: return "R5";
            4: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic check(input string tag, input logic [WB-1:0] act, input logic [WB-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apply_and_wait(input int op, input logic [WB-1:0] a, input logic [WB-1:0] b);
        @(negedge clk);
        op_sel = op[2:0]; opnd_a = a; opnd_b = b; in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [WB-1:0] a, b, e, b2;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11: reset state
        check("R11 res", res, '0);
        check("R11 flags", {10'd0, err, out_valid}, '0);
        rst = 1'b0;

        // R2..R7, R9: sweep all trit pairs, rotated across positions
        for (int op = 0; op < 8; op++) begin
            for (int k = 0; k < 9; k++) begin
                for (int i = 0; i < TRITS; i++) begin
                    int c = (k + i) % 9;
                    int x = c / 3 - 1;
                    int y = c % 3 - 1;
                    a[2*i +: 2] = enc(x);
                    b[2*i +: 2] = enc(y);
                    e[2*i +: 2] = enc(ref_fn(op, x, y));
                end
                apply_and_wait(op, a, b);
                check({tag_of(op), " R9 R1 word"}, res, e);
                check({tag_of(op), " R10 valid/err"}, {10'd0, out_valid, err}, 12'b10);
            end
        end

        // R4: B has no effect on negation
        a = {enc(1), enc(0), enc(-1), enc(1), enc(-1), enc(0)};
        e = {enc(-1), enc(0), enc(1), enc(-1), enc(1), enc(0)};
        apply_and_wait(2, a, {6{2'b01}});
        check("R4 B=+ ignored", res, e);
        apply_and_wait(2, a, {6{2'b10}});
        check("R4 B=- ignored", res, e);

        // R10: hold while in_valid low
        @(negedge clk);
        opnd_a = {6{2'b01}}; opnd_b = {6{2'b01}}; op_sel = 3'd1;
        @(posedge clk); @(negedge clk);
        check("R10 hold res", res, e);
        check("R10 hold valid", {11'd0, out_valid}, '0);

        // R8: illegal in A at trit 2 under MIN
        a = {enc(1), enc(1), enc(1), 2'b11, enc(0), enc(-1)};
        b = {enc(0), enc(-1), enc(1), enc(1), enc(1), enc(1)};
        e = {enc(0), enc(-1), enc(1), 2'b00, enc(0), enc(-1)};
        apply_and_wait(0, a, b);
        check("R8 zeroed trit A", res, e);
        check("R8 err A", {11'd0, err}, 12'd1);

        // R8: illegal only in B under NEG still flags
        a = {enc(1), enc(0), enc(-1), enc(1), enc(0), enc(-1)};
        b2 = {2'b11, 10'd0};
        e = {2'b00, enc(0), enc(1), enc(-1), enc(0), enc(1)};
        apply_and_wait(2, a, b2);
        check("R8 zeroed trit B", res, e);
        check("R8 err B", {11'd0, err}, 12'd1);

        // R8: err clears on next clean input
        apply_and_wait(7, a, '0);
        check("R8 err clears", {11'd0, err}, '0);
        check("R7 pass after error", res, a);

        // R11: reset mid-run with in_valid high
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b1; op_sel = 3'd7; opnd_a = {6{2'b01}};
        @(posedge clk); @(negedge clk);
        check("R11 reset res", res, '0);
        check("R11 reset flags", {10'd0, err, out_valid}, '0);
        rst = 1'b0; in_valid = 1'b0;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule